// File: doc/BRIEF.md
# Grouped Channel Slot Allocator

This block hands out channel slot numbers for a DMA engine. It keeps one free bitmap for transmit slots and one for receive slots, 64 of each by default. On a request it grants the lowest-numbered free slot and marks that slot as used. Slots come back through a release port.

A transmit request carries a two-bit group code. The code limits the grant to a low window (slots 0 to 9), a high window (slots 10 to 63), or the whole range. Receive requests always search the whole range. When nothing is free in the allowed range, the request reports no-space and changes no state.

The transmit and receive pools are independent, so a transmit request and a receive request in the same cycle are both served. Every result is registered and appears one cycle after the request.

Top module: `slot_alloc`

## Requirements
- R1: After reset every transmit and receive slot is free, and all grant, no-space and release-error outputs are 0.
- R2: A transmit request with `tx_grp` = 2'b01 (low group) is granted only a slot in 0..9.
- R3: A transmit request with `tx_grp` = 2'b10 (high group) is granted only a slot in 10..63.
- R4: A transmit request with `tx_grp` = 2'b00 or 2'b11 may be granted any slot in 0..63. A receive request always searches 0..63.
- R5: The grant is the lowest free slot inside the allowed range. If that range has no free slot, the no-space output is raised instead of a grant, and neither bitmap changes.
- R6: A grant marks its slot used in the same cycle, so the same index is never granted twice while it is held. A transmit request and a receive request in the same cycle are both served.
- R7: A release (`rel_is_tx` = 1 selects transmit, 0 selects receive) of a used slot makes it free. A release of a slot that is already free raises `rel_err` one cycle later and leaves the bitmap unchanged.
- R8: When a release and a request occur in the same cycle, the release is applied first, so the released slot can be granted to that request.
- R9: Every request and release is a one-cycle pulse. Its result (grant valid with index, or no-space, or release error) is valid exactly in the following cycle and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Transmit slot request pulse |
| tx_grp | input | 2 | Group code: 01 low window, 10 high window, 00/11 full range |
| rx_req | input | 1 | Receive slot request pulse |
| rel_vld | input | 1 | Release pulse |
| rel_is_tx | input | 1 | Release targets transmit pool (1) or receive pool (0) |
| rel_idx | input | IW | Slot index being released |
| tx_gnt_vld | output | 1 | Transmit grant valid |
| tx_gnt_idx | output | IW | Granted transmit slot |
| tx_nospace | output | 1 | Transmit request found no free slot in its range |
| rx_gnt_vld | output | 1 | Receive grant valid |
| rx_gnt_idx | output | IW | Granted receive slot |
| rx_nospace | output | 1 | Receive request found no free slot |
| rel_err | output | 1 | The last release targeted a slot that was already free |

## Verification
Two cases are hard to reach. The first is a no-space result in one transmit window while the other window still has free slots. The second is a release that lands in the same cycle as a request for the slot it frees. The stimulus reaches the first by running requests in the low group until all ten low slots are taken. It then shows that a full-range request still succeeds, and later drains the high window the same way. For the second, it releases a slot in the middle of the filled low window in the same cycle as a low-group request, and expects that slot back as the grant. A long random phase, checked against a reference bitmap, then mixes coincident requests, double releases and exhaustion.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

   // Transmit group code (bit 0 = low window, bit 1 = high window)
   typedef enum logic [1:0] {
      GRP_ANY  = 2'b00,
      GRP_LOW  = 2'b01,
      GRP_HIGH = 2'b10,
      GRP_BOTH = 2'b11
   } grp_sel_e;

endpackage

// File: rtl/lowest_free_finder.sv
module lowest_free_finder #(
   parameter int N  = 64,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);

   if (N < 2) begin : g_bad_n
      $error("lowest_free_finder: N must be at least 2");
   end

   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/slot_pool.sv
module slot_pool
   import slot_alloc_pkg::*;
#(
   parameter int N        = 64,
   parameter int SPLIT    = 10,
   parameter bit WINDOWED = 1'b1,
   parameter int IW       = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [1:0]    grp,
   input  logic          rel_vld,
   input  logic [IW-1:0] rel_idx,
   output logic          gnt_vld,
   output logic [IW-1:0] gnt_idx,
   output logic          nospace,
   output logic          rel_err
);

   localparam logic [N-1:0] ONE      = {{(N-1){1'b0}}, 1'b1};
   localparam logic [N-1:0] LOW_MASK = (ONE << SPLIT) - ONE;
   localparam logic [N-1:0] HIGH_MASK = ~LOW_MASK;

   if (SPLIT < 1 || SPLIT >= N) begin : g_bad_split
      $error("slot_pool: SPLIT must lie inside 1..N-1");
   end

   logic [N-1:0]  free_q, free_eff, free_d, win_mask, rel_oh;
   logic          hit;
   logic [IW-1:0] hit_idx;

   if (WINDOWED) begin : g_win
      always_comb begin
         unique case (grp_sel_e'(grp))
            GRP_LOW:  win_mask = LOW_MASK;
            GRP_HIGH: win_mask = HIGH_MASK;
            default:  win_mask = '1;
         endcase
      end
   end else begin : g_full
      logic grp_unused;
      assign grp_unused = ^grp;
      assign win_mask   = '1;
   end

   // Release is merged before the search so a coincident request sees it
   assign rel_oh   = rel_vld ? (ONE << rel_idx) : '0;
   assign free_eff = free_q | rel_oh;

   lowest_free_finder #(.N(N), .IW(IW)) u_find (
      .vec   (free_eff & win_mask),
      .found (hit),
      .idx   (hit_idx)
   );

   assign free_d = (req && hit) ? (free_eff & ~(ONE << hit_idx)) : free_eff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q  <= '1;
         gnt_vld <= 1'b0;
         gnt_idx <= '0;
         nospace <= 1'b0;
         rel_err <= 1'b0;
      end else begin
         free_q  <= free_d;
         gnt_vld <= req && hit;
         nospace <= req && !hit;
         rel_err <= rel_vld && free_q[rel_idx];
         if (req && hit) gnt_idx <= hit_idx;
      end
   end

   AST_GNT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |-> !free_q[gnt_idx]);                                   // R6
   AST_GNT_OR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      !(gnt_vld && nospace));                                          // R5
   AST_FULL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (nospace && !$past(rel_vld)) |-> (free_q == $past(free_q)));     // R5
   AST_REL_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rel_err |-> $past(rel_vld));                                     // R7

endmodule

// File: rtl/slot_alloc.sv
module slot_alloc
   import slot_alloc_pkg::*;
#(
   parameter int SLOTS     = 64,
   parameter int LOW_SPLIT = 10,
   localparam int IW       = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_req,
   input  logic [1:0]    tx_grp,
   input  logic          rx_req,
   input  logic          rel_vld,
   input  logic          rel_is_tx,
   input  logic [IW-1:0] rel_idx,
   output logic          tx_gnt_vld,
   output logic [IW-1:0] tx_gnt_idx,
   output logic          tx_nospace,
   output logic          rx_gnt_vld,
   output logic [IW-1:0] rx_gnt_idx,
   output logic          rx_nospace,
   output logic          rel_err
);

   logic tx_rel_err, rx_rel_err;

   slot_pool #(.N(SLOTS), .SPLIT(LOW_SPLIT), .WINDOWED(1'b1), .IW(IW)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (tx_req),
      .grp     (tx_grp),
      .rel_vld (rel_vld && rel_is_tx),
      .rel_idx (rel_idx),
      .gnt_vld (tx_gnt_vld),
      .gnt_idx (tx_gnt_idx),
      .nospace (tx_nospace),
      .rel_err (tx_rel_err)
   );

   slot_pool #(.N(SLOTS), .SPLIT(LOW_SPLIT), .WINDOWED(1'b0), .IW(IW)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (rx_req),
      .grp     (GRP_ANY),
      .rel_vld (rel_vld && !rel_is_tx),
      .rel_idx (rel_idx),
      .gnt_vld (rx_gnt_vld),
      .gnt_idx (rx_gnt_idx),
      .nospace (rx_nospace),
      .rel_err (rx_rel_err)
   );

   assign rel_err = tx_rel_err | rx_rel_err;

   AST_LOW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_gnt_vld && $past(tx_grp) == GRP_LOW) |-> (int'(tx_gnt_idx) < LOW_SPLIT));   // R2
   AST_HIGH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_gnt_vld && $past(tx_grp) == GRP_HIGH) |-> (int'(tx_gnt_idx) >= LOW_SPLIT)); // R3
   AST_TX_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_gnt_vld || tx_nospace) |-> $past(tx_req));                                   // R9
   AST_RX_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_gnt_vld || rx_nospace) |-> $past(rx_req));                                   // R9

endmodule

// File: tb/slot_alloc_test.sv
`timescale 1ns/1ps
module slot_alloc_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_req = 1'b0, rx_req = 1'b0, rel_vld = 1'b0, rel_is_tx = 1'b0;
   logic [1:0] tx_grp = 2'b00;
   logic [5:0] rel_idx = '0;
   logic       tx_gnt_vld, tx_nospace, rx_gnt_vld, rx_nospace, rel_err;
   logic [5:0] tx_gnt_idx, rx_gnt_idx;

   int nchk = 0, nfail = 0, ncyc = 0;
   bit [63:0] mtx, mrx;

   always #2 clk = ~clk;

   slot_alloc uut (
      .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_grp(tx_grp), .rx_req(rx_req),
      .rel_vld(rel_vld), .rel_is_tx(rel_is_tx), .rel_idx(rel_idx),
      .tx_gnt_vld(tx_gnt_vld), .tx_gnt_idx(tx_gnt_idx), .tx_nospace(tx_nospace),
      .rx_gnt_vld(rx_gnt_vld), .rx_gnt_idx(rx_gnt_idx), .rx_nospace(rx_nospace),
      .rel_err(rel_err)
   );

   // vector: op[16:15] (0 tx req, 1 rx req, 2 tx release, 3 rx release),
   // grp[14:13], idx[12:7], expected flag[6], expected index[5:0]
   localparam logic [16:0] VEC [14] = '{
      {2'd0, 2'b01, 6'd0,  1'b0, 6'd0},
      {2'd0, 2'b10, 6'd0,  1'b0, 6'd10},
      {2'd0, 2'b00, 6'd0,  1'b0, 6'd1},
      {2'd0, 2'b11, 6'd0,  1'b0, 6'd2},
      {2'd1, 2'b00, 6'd0,  1'b0, 6'd0},
      {2'd1, 2'b00, 6'd0,  1'b0, 6'd1},
      {2'd2, 2'b00, 6'd1,  1'b0, 6'd0},
      {2'd2, 2'b00, 6'd1,  1'b1, 6'd0},
      {2'd0, 2'b00, 6'd0,  1'b0, 6'd1},
      {2'd3, 2'b00, 6'd0,  1'b0, 6'd0},
      {2'd1, 2'b00, 6'd0,  1'b0, 6'd0},
      {2'd2, 2'b00, 6'd10, 1'b0, 6'd0},
      {2'd0, 2'b10, 6'd0,  1'b0, 6'd10},
      {2'd3, 2'b00, 6'd63, 1'b1, 6'd0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // One request/release cycle, checked against the reference bitmaps
   task automatic cyc(input bit treq, input logic [1:0] g, input bit rreq,
                      input bit rv, input bit rtx, input logic [5:0] ri);
      int lo, hi, et, er;
      bit erel;
      tx_req = treq; tx_grp = g; rx_req = rreq;
      rel_vld = rv; rel_is_tx = rtx; rel_idx = ri;
      @(negedge clk);
      erel = 1'b0;
      if (rv) begin
         erel = rtx ? mtx[ri] : mrx[ri];
         if (rtx) mtx[ri] = 1'b1; else mrx[ri] = 1'b1;   // R8 release first
      end
      lo = (g == 2'b10) ? 10 : 0;
      hi = (g == 2'b01) ? 10 : 64;
      et = -1;
      for (int i = hi - 1; i >= lo; i--) if (mtx[i]) et = i;
      er = -1;
      for (int i = 63; i >= 0; i--) if (mrx[i]) er = i;
      if (treq) begin
         chk("R5 tx grant valid", int'(tx_gnt_vld), int'(et >= 0));
         chk("R5 tx nospace", int'(tx_nospace), int'(et < 0));
         if (et >= 0) begin
            chk("R5 tx lowest index", int'(tx_gnt_idx), et);
            mtx[et] = 1'b0;
         end
      end else begin
         chk("R9 tx idle", int'(tx_gnt_vld | tx_nospace), 0);
      end
      if (rreq) begin
         chk("R6 rx grant valid", int'(rx_gnt_vld), int'(er >= 0));
         chk("R5 rx nospace", int'(rx_nospace), int'(er < 0));
         if (er >= 0) begin
            chk("R4 rx lowest index", int'(rx_gnt_idx), er);
            mrx[er] = 1'b0;
         end
      end else begin
         chk("R9 rx idle", int'(rx_gnt_vld | rx_nospace), 0);
      end
      chk("R7 release error", int'(rel_err), int'(erel));
      tx_req = 1'b0; rx_req = 1'b0; rel_vld = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mtx = '1; mrx = '1;
      @(negedge clk);
      chk("R1 reset outputs", int'({tx_gnt_vld, tx_nospace, rx_gnt_vld, rx_nospace, rel_err}), 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         ncyc++;
         if (ncyc > 150000) begin
            nfail++;
            $display("FAIL watchdog: got %0d cycles expected completion", ncyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
         end
      end
   end

   initial begin
      logic [16:0] v;
      @(negedge clk);
      do_reset();

      // Table walk
      foreach (VEC[k]) begin
         v = VEC[k];
         case (v[16:15])
            2'd0: cyc(1'b1, v[14:13], 1'b0, 1'b0, 1'b0, 6'd0);
            2'd1: cyc(1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 6'd0);
            2'd2: cyc(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, v[12:7]);
            default: cyc(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, v[12:7]);
         endcase
         if (v[16:15] == 2'd0) begin
            chk("R2 R3 R4 table tx nospace", int'(tx_nospace), int'(v[6]));
            chk("R2 R3 R4 table tx index", int'(tx_gnt_idx), int'(v[5:0]));
         end else if (v[16:15] == 2'd1) begin
            chk("R1 table rx index", int'(rx_gnt_idx), int'(v[5:0]));
         end else begin
            chk("R7 table release error", int'(rel_err), int'(v[6]));
         end
      end

      // R9: result lasts one cycle only
      cyc(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 6'd0);
      chk("R9 grant dropped", int'(tx_gnt_vld), 0);

      // R2/R5: drain the low window, then no-space while high slots remain
      for (int k = 3; k <= 9; k++) begin
         cyc(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 6'd0);
         chk("R2 low window fill", int'(tx_gnt_idx), k);
      end
      cyc(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 6'd0);
      chk("R5 low window full", int'(tx_nospace), 1);
      cyc(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 6'd0);
      chk("R4 full range after low full", int'(tx_gnt_idx), 11);

      // R8: release and request of the same slot together
      cyc(1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 6'd5);
      chk("R8 released slot regranted", int'(tx_gnt_idx), 5);
      chk("R8 no release error", int'(rel_err), 0);

      // R6: transmit and receive served in one cycle
      cyc(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 6'd0);
      chk("R6 tx same cycle", int'(tx_gnt_idx), 12);
      chk("R6 rx same cycle", int'(rx_gnt_idx), 2);

      // R3: drain the high window
      for (int k = 13; k <= 63; k++) begin
         cyc(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 6'd0);
         chk("R3 high window fill", int'(tx_gnt_idx), k);
      end
      cyc(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 6'd0);
      chk("R5 high window full", int'(tx_nospace), 1);
      cyc(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 6'd0);
      chk("R4 all slots taken", int'(tx_nospace), 1);

      // Random phase against the reference bitmaps
      do_reset();
      cyc(1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 6'd0);
      chk("R1 first grant after reset", int'(tx_gnt_idx) + int'(rx_gnt_idx), 0);
      for (int n = 0; n < 4000; n++) begin
         cyc(bit'($urandom_range(0, 3) != 0), 2'($urandom), bit'($urandom_range(0, 3) != 0),
             bit'($urandom_range(0, 1)), bit'($urandom), 6'($urandom));
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule